// File: doc/BRIEF.md
# Buffered Page Program Sequencer with Compare Verify

This block writes an arbitrary byte range into a page-organised serial flash. It goes through the flash's internal SRAM buffer. It cuts the request into chunks at page boundaries. A chunk that does not cover a whole page begins with a command that copies the current flash page into the buffer. This keeps the untouched bytes of that page. Each chunk is then sent as one program-through-buffer transaction: the opcode, three address bytes, then the data bytes drawn from an input byte stream. After the program step the block can issue a buffer-against-flash compare and read the mismatch flag from the status byte. A mismatch stops the whole request and reports the failing page.

The flash side is a byte-level command stream toward an external serial shifter. The shifter returns exactly one response byte for every byte it accepts, at least one cycle later. The block keeps one byte outstanding at a time. On both streams, a byte transfers on a clock edge where valid and ready are both high. While a stream is stalled, its sender holds valid, data and the last flag stable. The input data stream must follow the same rule. Its bytes are requested only during the data phase of a program command, so the upstream source sees back-pressure everywhere else. `sp_last` marks the final byte of a command, and the shifter deselects the flash after that byte.

Start offset, length, page size, page-address shift and the verify enable are sampled or used while `busy` is high. They must stay constant until `done`.

Top module: `pageprog_seq`

## Requirements
- R1: The first chunk is min(length, page_size − offset mod page_size) bytes long. Each later chunk is min(remaining, page_size) bytes long and starts at in-page column 0. The page number starts at offset div page_size and goes up by one per chunk.
- R2: A chunk shorter than page_size is preceded by the 4-byte command 0x53, A[23:16], A[15:8], 0x00, where A is the page address. A full-page chunk sends no such command.
- R3: Each chunk is programmed by one transaction: 0x82, then the three bytes of (A + column) with the most significant byte first, then the chunk's data bytes. `sp_last` is high only on the final data byte.
- R4: The page address A is the page number shifted left by `page_shift`, truncated to 24 bits.
- R5: After every load, program and compare command, the block polls status. Each poll is the two-byte transaction 0xD7, 0x00, with `sp_last` on the second byte. The response to the second byte is the status. Polling repeats while status bit 7 is 0.
- R6: With `verify_en` high, each program is followed by 0x60, A[23:16], A[15:8], 0x00 and a poll. If the ready status has bit 6 set, the request ends with `verify_fail` high and `fail_page` equal to that chunk's page number, and no further bytes are sent.
- R7: With `verify_en` low, no compare command is sent and `verify_fail` stays low.
- R8: `in_ready` is high only in the program data phase. Exactly the programmed chunk bytes are taken from the input stream, in order, and forwarded unchanged.
- R9: At most one command byte is outstanding: after a byte is accepted, `sp_valid` stays low until its response arrives. A stalled byte is held stable.
- R10: `done` is a one-cycle pulse with `busy` low. A request of length 0 completes with no flash traffic.
- R11: After reset, `busy`, `done`, `sp_valid`, `in_ready` and `verify_fail` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a request (taken while idle) |
| start_offset | input | AW | Byte offset of the first byte |
| byte_count | input | LW | Number of bytes to write |
| page_size | input | PW | Bytes per flash page, at least 1 |
| page_shift | input | SW | Left shift turning a page number into a page address (8 or more) |
| verify_en | input | 1 | Run a compare after every program |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| verify_fail | output | 1 | Last request ended on a compare mismatch |
| fail_page | output | AW | Page number of the mismatch |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Input byte taken |
| in_data | input | 8 | Input byte |
| sp_valid | output | 1 | Command byte valid |
| sp_ready | input | 1 | Shifter accepts the byte |
| sp_data | output | 8 | Command byte |
| sp_last | output | 1 | Final byte of the command |
| sp_rsp_valid | input | 1 | Response byte valid |
| sp_rsp_data | input | 8 | Response byte |

## Verification
The bench sweeps every start column against every length up to two pages on a page size that is not a power of two. It predicts the complete command byte stream arithmetically, so a wrong split would show as a chunk one byte long or short. A missing or spurious load command would show on full pages, and a program address that ignores the column would show on partial pages. Random stalls on the shifter and gaps on the input stream target a design that drops or repeats a byte under back-pressure. Compare failures on the first and on a later chunk, a slow device needing repeated polls, and a far page with high address bits target a design that keeps going after a mismatch, reports the wrong page, or mis-shifts the page address.

// File: rtl/pp_pkg.sv
package pp_pkg;
  localparam logic [7:0] OP_LOAD = 8'h53;
  localparam logic [7:0] OP_PROG = 8'h82;
  localparam logic [7:0] OP_CMP  = 8'h60;
  localparam logic [7:0] OP_STAT = 8'hD7;
  localparam int BIT_RDY  = 7;
  localparam int BIT_MISS = 6;

  typedef enum logic [1:0] {K_LOAD, K_PROG, K_CMP, K_STAT} cmd_e;
  typedef enum logic [2:0] {S_IDLE, S_DIV, S_PLAN, S_HDR, S_DATA, S_NEXT, S_DONE} st_e;
endpackage

// File: rtl/pp_chunker.sv
module pp_chunker #(
  parameter int AW = 24,
  parameter int LW = 16,
  parameter int PW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          step,
  input  logic [AW-1:0] off,
  input  logic [LW-1:0] len,
  input  logic [PW-1:0] psz,
  output logic          ready,
  output logic [AW-1:0] page,
  output logic [PW-1:0] col,
  output logic [LW-1:0] chunk,
  output logic          last
);
  logic [AW-1:0] rem_off;
  logic [LW-1:0] remaining;
  logic          dividing;
  logic [AW-1:0] psz_x;
  logic [LW-1:0] space_x;

  assign psz_x   = AW'(psz);
  assign space_x = LW'(psz - col);
  assign chunk   = (remaining < space_x) ? remaining : space_x;
  assign last    = (remaining <= space_x);
  assign ready   = !dividing;

  // offset is divided by repeated subtraction: one page per cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_off   <= '0;
      remaining <= '0;
      dividing  <= 1'b0;
      page      <= '0;
      col       <= '0;
    end else if (load) begin
      rem_off   <= off;
      remaining <= len;
      dividing  <= 1'b1;
      page      <= '0;
      col       <= '0;
    end else if (dividing) begin
      if (rem_off >= psz_x) begin
        rem_off <= rem_off - psz_x;
        page    <= page + AW'(1);
      end else begin
        dividing <= 1'b0;
        col      <= rem_off[PW-1:0];
      end
    end else if (step) begin
      remaining <= remaining - chunk;
      page      <= page + AW'(1);
      col       <= '0;
    end
  end

  // R1: a pending chunk is never empty and never wider than a page
  a_r1_chunk_fits: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && remaining != '0) |-> (chunk != '0 && chunk <= LW'(psz)));
  // R1: after a step the next chunk begins at column 0
  a_r1_step_col0: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load && ready) |=> (col == '0));
endmodule

// File: rtl/pageprog_seq.sv
module pageprog_seq #(
  parameter int AW = 24,
  parameter int LW = 16,
  parameter int PW = 11,
  parameter int SW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] start_offset,
  input  logic [LW-1:0] byte_count,
  input  logic [PW-1:0] page_size,
  input  logic [SW-1:0] page_shift,
  input  logic          verify_en,
  output logic          busy,
  output logic          done,
  output logic          verify_fail,
  output logic [AW-1:0] fail_page,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [7:0]    in_data,
  output logic          sp_valid,
  input  logic          sp_ready,
  output logic [7:0]    sp_data,
  output logic          sp_last,
  input  logic          sp_rsp_valid,
  input  logic [7:0]    sp_rsp_data
);
  import pp_pkg::*;

  localparam int ADDR_BITS = 24;
  localparam logic [LW-1:0] ONE = LW'(1);

  st_e           st;
  cmd_e          kind, polled;
  logic [1:0]    idx;
  logic [LW-1:0] cnt;
  logic          wait_rsp, seg_end;

  logic          ck_ready, ck_last, ck_step, ck_load;
  logic [AW-1:0] ck_page;
  logic [PW-1:0] ck_col;
  logic [LW-1:0] ck_chunk;

  assign ck_load = (st == S_IDLE) && start && (byte_count != '0);
  assign ck_step = (st == S_NEXT) && !ck_last;

  pp_chunker #(.AW(AW), .LW(LW), .PW(PW)) u_chunk (
    .clk(clk), .rst_n(rst_n), .load(ck_load), .step(ck_step),
    .off(start_offset), .len(byte_count), .psz(page_size),
    .ready(ck_ready), .page(ck_page), .col(ck_col),
    .chunk(ck_chunk), .last(ck_last)
  );

  // address formation
  logic [ADDR_BITS-1:0] pg_addr, full_addr, hdr_addr;
  assign pg_addr   = ADDR_BITS'(ck_page << page_shift);
  assign full_addr = pg_addr + ADDR_BITS'(ck_col);
  assign hdr_addr  = (kind == K_PROG) ? full_addr : {pg_addr[23:8], 8'h00};

  logic [7:0] op_byte, hdr_byte;
  always_comb begin
    unique case (kind)
      K_LOAD:  op_byte = OP_LOAD;
      K_PROG:  op_byte = OP_PROG;
      K_CMP:   op_byte = OP_CMP;
      default: op_byte = OP_STAT;
    endcase
    unique case (idx)
      2'd0:    hdr_byte = op_byte;
      2'd1:    hdr_byte = (kind == K_STAT) ? 8'h00 : hdr_addr[23:16];
      2'd2:    hdr_byte = hdr_addr[15:8];
      default: hdr_byte = hdr_addr[7:0];
    endcase
  end

  logic hdr_end, data_end, phase_end, fire, rsp_take;
  assign hdr_end   = (kind == K_STAT) ? (idx == 2'd1) : (idx == 2'd3);
  assign data_end  = (cnt == ck_chunk - ONE);
  assign phase_end = (st == S_DATA) ? data_end : hdr_end;

  assign sp_valid = !wait_rsp && ((st == S_HDR) || (st == S_DATA && in_valid));
  assign sp_data  = (st == S_DATA) ? in_data : hdr_byte;
  assign sp_last  = (st == S_DATA) ? data_end : (hdr_end && kind != K_PROG);
  assign in_ready = (st == S_DATA) && !wait_rsp && sp_ready;
  assign fire     = sp_valid && sp_ready;
  assign rsp_take = wait_rsp && sp_rsp_valid;
  assign busy     = (st != S_IDLE);

  logic unused_rsp;
  assign unused_rsp = ^sp_rsp_data[5:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= S_IDLE;
      kind        <= K_STAT;
      polled      <= K_STAT;
      idx         <= '0;
      cnt         <= '0;
      wait_rsp    <= 1'b0;
      seg_end     <= 1'b0;
      done        <= 1'b0;
      verify_fail <= 1'b0;
      fail_page   <= '0;
    end else begin
      done <= 1'b0;
      unique case (st)
        S_IDLE: if (start) begin
          verify_fail <= 1'b0;
          st <= (byte_count == '0) ? S_DONE : S_DIV;
        end
        S_DIV: if (ck_ready) st <= S_PLAN;
        S_PLAN: begin
          kind <= (ck_chunk != LW'(page_size)) ? K_LOAD : K_PROG;
          idx  <= '0;
          st   <= S_HDR;
        end
        S_HDR, S_DATA: begin
          if (fire) begin
            wait_rsp <= 1'b1;
            seg_end  <= phase_end;
            if (st == S_HDR) idx <= idx + 2'd1;
            else             cnt <= cnt + ONE;
          end else if (rsp_take) begin
            wait_rsp <= 1'b0;
            if (seg_end) begin
              if (st == S_HDR && kind == K_PROG) begin
                st  <= S_DATA;
                cnt <= '0;
              end else if (kind == K_STAT) begin
                idx <= '0;
                if (sp_rsp_data[BIT_RDY]) begin
                  unique case (polled)
                    K_LOAD: kind <= K_PROG;
                    K_PROG: if (verify_en) kind <= K_CMP;
                            else st <= S_NEXT;
                    default: if (sp_rsp_data[BIT_MISS]) begin
                      verify_fail <= 1'b1;
                      fail_page   <= ck_page;
                      st          <= S_DONE;
                    end else st <= S_NEXT;
                  endcase
                end
              end else begin
                polled <= kind;
                kind   <= K_STAT;
                idx    <= '0;
                st     <= S_HDR;
              end
            end
          end
        end
        S_NEXT: st <= ck_last ? S_DONE : S_PLAN;
        default: begin
          done <= 1'b1;
          st   <= S_IDLE;
        end
      endcase
    end
  end

  // R9: stalled command byte is held
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (sp_valid && !sp_ready) |=> (sp_valid && $stable(sp_data) && $stable(sp_last)));
  // R9: one byte outstanding
  a_r9_one_out: assert property (@(posedge clk) disable iff (!rst_n)
    (sp_valid && sp_ready) |=> !sp_valid);
  // R10: completion is a single pulse while idle
  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r10_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  // R6: a mismatch ends the request on the next cycle
  a_r6_fail_ends: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(verify_fail) |=> done);
  // R8: input bytes are taken only while a command byte can be forwarded
  a_r8_in_gate: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> (busy && sp_ready && !done));
endmodule

// File: tb/tb_pageprog_seq.sv
`timescale 1ns/1ps
module tb_pageprog_seq;
  localparam int AW = 24, LW = 16, PW = 11, SW = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0;
  logic [AW-1:0] start_offset = '0;
  logic [LW-1:0] byte_count = '0;
  logic [PW-1:0] page_size = PW'(6);
  logic [SW-1:0] page_shift = SW'(8);
  logic verify_en = 1'b0;
  logic busy, done, verify_fail;
  logic [AW-1:0] fail_page;
  logic in_valid = 1'b0, in_ready;
  logic [7:0] in_data = '0;
  logic sp_valid, sp_ready = 1'b0, sp_last;
  logic [7:0] sp_data;
  logic sp_rsp_valid = 1'b0;
  logic [7:0] sp_rsp_data = '0;

  pageprog_seq #(.AW(AW), .LW(LW), .PW(PW), .SW(SW)) dut (.*);

  always #2.5 clk = ~clk;

  int checks = 0, errors = 0, cycles = 0;
  logic [8:0] exq[$];
  int logi, mism, dcnt, cmp_seen, bad_cmp, busy_n = 1, busy_left, tb_idx;
  int ps = 6, sh = 8, efail, epage, econs;
  logic [7:0] seed, tx_op, pend_byte;
  logic pend = 1'b0, took = 1'b0, act = 1'b0, cmp_fail = 1'b0;
  logic [15:0] lfsr = 16'hACE1;

  task automatic check(input bit ok, input string tag, input longint a, input longint e);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, a, e);
    end
  endtask

  // shifter, flash status model and input source
  always @(negedge clk) begin
    cycles++;
    sp_rsp_valid = pend; sp_rsp_data = pend_byte; pend = 1'b0;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    sp_ready = lfsr[0] | lfsr[1];
    if (took || !in_valid || !act) begin
      in_valid = act && lfsr[2];
      in_data = seed + dcnt[7:0];
      took = 1'b0;
    end
    #1;
    if (sp_valid && sp_ready) begin
      if (logi >= exq.size() || exq[logi] != {sp_last, sp_data}) begin
        if (mism == 0)
          $display("FAIL R3 stream byte %0d actual=%0h expected=%0h", logi,
                   {sp_last, sp_data}, (logi < exq.size()) ? exq[logi] : 9'h1FF);
        mism++;
      end
      logi++;
      if (tb_idx == 0) tx_op = sp_data;
      pend_byte = 8'h3C;
      if (tx_op == 8'hD7 && tb_idx == 1) begin
        if (busy_left > 0) begin pend_byte = 8'h00; busy_left--; end
        else pend_byte = cmp_fail ? 8'hC0 : 8'h80;
      end
      pend = 1'b1;
      if (sp_last) begin
        tb_idx = 0;
        if (tx_op != 8'hD7) begin
          busy_left = busy_n; cmp_fail = 1'b0;
          if (tx_op == 8'h60) begin
            if (cmp_seen == bad_cmp) cmp_fail = 1'b1;
            cmp_seen++;
          end
        end
      end else tb_idx++;
    end
    if (in_valid && in_ready) begin dcnt++; took = 1'b1; end
  end

  task automatic push_polls();
    for (int p = 0; p <= busy_n; p++) begin
      exq.push_back({1'b0, 8'hD7}); exq.push_back({1'b1, 8'h00});
    end
  endtask

  task automatic push_hdr(input logic [7:0] op, input int a, input bit lst);
    exq.push_back({1'b0, op});
    exq.push_back({1'b0, 8'(a >> 16)});
    exq.push_back({1'b0, 8'(a >> 8)});
    exq.push_back({lst, 8'(a)});
  endtask

  task automatic build(input int off, input int len, input int ver, input int bad);
    int page, col, rem, c, pa, k;
    exq.delete(); efail = 0; epage = 0; econs = 0; k = 0;
    page = off / ps; col = off % ps; rem = len;
    while (rem > 0) begin
      c = (rem < ps - col) ? rem : ps - col;            // R1
      pa = (page << sh) & 32'hFFFFFF;                   // R4
      if (c != ps) begin push_hdr(8'h53, pa & 32'hFFFF00, 1'b1); push_polls(); end  // R2
      push_hdr(8'h82, pa + col, 1'b0);                   // R3
      for (int i = 0; i < c; i++) exq.push_back({(i == c - 1), 8'(seed + 8'(econs + i))});
      econs += c; push_polls();                          // R5
      if (ver != 0) begin                                // R6
        push_hdr(8'h60, pa & 32'hFFFF00, 1'b1); push_polls();
        if (k == bad) begin efail = 1; epage = page; break; end
        k++;
      end
      rem -= c; page++; col = 0;
    end
  endtask

  task automatic run_op(input int off, input int len, input int ver, input int bad);
    int t;
    @(negedge clk);
    seed = 8'(off * 7 + len * 13); build(off, len, ver, bad);
    logi = 0; mism = 0; dcnt = 0; cmp_seen = 0; bad_cmp = bad; tb_idx = 0; act = 1'b1;
    start = 1'b1; start_offset = AW'(off); byte_count = LW'(len);
    page_size = PW'(ps); page_shift = SW'(sh); verify_en = (ver != 0);
    @(negedge clk); start = 1'b0;
    t = 0;
    while (!done && t < 20000) begin @(negedge clk); t++; end
    check(done, "R10 completion", done, 1);
    check(!busy, "R10 idle at done", busy, 0);
    check(mism == 0 && logi == exq.size(), "R1/R2/R3/R4/R5 command stream", logi, exq.size());
    check(dcnt == econs, "R8 bytes consumed", dcnt, econs);
    check(verify_fail == efail, ver ? "R6 verify flag" : "R7 no verify", verify_fail, efail);
    if (efail != 0) check(fail_page == AW'(epage), "R6 failing page", fail_page, epage);
    act = 1'b0;
    @(negedge clk);
    check(!done, "R10 done one cycle", done, 0);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(!busy && !done && !sp_valid && !in_ready && !verify_fail, "R11 reset state",
          {busy, done, sp_valid, in_ready, verify_fail}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    // near-exhaustive sweep: page of 6 bytes, every column, lengths up to two pages
    for (int off = 0; off <= 12; off++)
      for (int len = 1; len <= 12; len++)
        run_op(off, len, (off + len) & 1, -1);
    // power-of-two page, wider shift
    ps = 8; sh = 9;
    run_op(0, 8, 1, -1); run_op(5, 16, 1, -1); run_op(8, 3, 0, -1);
    // far page: high address bits
    ps = 6; sh = 8;
    run_op(1801, 7, 1, -1);
    // compare mismatch on later and first chunk
    run_op(4, 12, 1, 1);
    run_op(0, 18, 1, 0);
    // slow device: repeated polls
    busy_n = 3;
    run_op(2, 9, 1, -1);
    busy_n = 1;
    // zero length
    run_op(3, 0, 1, -1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    wait (cycles > 190000);
    checks++; errors++;
    $display("FAIL watchdog actual=%0d expected=0", cycles);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule